// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a blocking data cache placed between a processor and a slower main memory. It holds a parameterised number of blocks, each four 32-bit words wide, together with one tag, one valid flag and one modified flag per block. The processor issues one word read or write at a time through a valid/ready handshake and is held until that access is finished.

A request that finds its block resident completes after a single tag-compare cycle. A request that does not find its block goes to memory. If the block it replaces holds modified data, that block is first written out whole over a 128-bit memory port. The missing block is then fetched over the same port, and the controller repeats the compare so that the access completes as a hit. Writes that miss allocate the block first and then merge the new word into it. Memory answers each request with its own valid/ready handshake after any number of cycles.

Top module: `blk_wb_cache`

## Requirements
- R1: A byte address is split into a block offset (bits [3:0], word select in bits [3:2]), an index in the next log2(NUM_BLK) bits ([13:4] for 1024 blocks) and a tag in the remaining upper bits. On the memory data bus, word k of a block occupies bits [32k+31:32k].
- R2: After reset, cpu_ready and mem_valid are low and every block is invalid, so the first access to any address misses.
- R3: A read that hits raises cpu_ready one cycle after the request is accepted and returns the addressed word, with no memory request.
- R4: A write that hits replaces only the addressed word, marks the block modified and starts no memory traffic. The word is later seen by reads and is carried to memory on eviction.
- R5: A miss on an invalid or unmodified block issues exactly one memory read at the block-aligned address of the request and no memory write.
- R6: A miss on a modified block first writes the whole victim block to the address formed from the victim tag and the index, and then issues the read for the new block.
- R7: When a fetched block has been installed, the controller repeats the compare and completes the access as a hit. A write miss therefore ends with the new word merged into the fetched block.
- R8: Once mem_valid is raised, mem_valid, mem_wr, mem_addr and (for writes) mem_wdata stay unchanged until the cycle in which mem_ready is high.
- R9: cpu_ready is high for exactly one cycle per access and never while a memory request is outstanding.
- R10: A freshly fetched block is unmodified. If it is evicted before any processor write to it, no write-back takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the request |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access complete |
| mem_valid | output | 1 | Memory request present |
| mem_wr | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | 32 | Block-aligned memory byte address |
| mem_wdata | output | 128 | Block written back |
| mem_rdata | input | 128 | Block returned by memory |
| mem_ready | input | 1 | Memory completes the request in this cycle |

## Verification
The bench builds the controller with NUM_BLK = 4, so only two index bits separate blocks. Addresses 64 bytes apart then collide on the same entry, and every eviction path is reached within a handful of accesses: modified victims, clean victims, write misses and repeated re-fetches. The memory responder varies its latency from zero to several cycles, which exposes the hold rules of the memory handshake. A reference word memory is checked against every read during a long run of mixed reads and writes over sixty-four blocks.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMP  = 2'd1,
      ST_WB   = 2'd2,
      ST_FILL = 2'd3
   } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
   parameter int NUM_BLK = 1024,
   parameter int IDX_W   = 10,
   parameter int TAG_W   = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag_q,
   output logic             valid_q,
   output logic             dirty_q,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             mark_dirty
);
   logic [NUM_BLK-1:0] valid_r;
   logic [NUM_BLK-1:0] dirty_r;
   logic [TAG_W-1:0]   tag_r [NUM_BLK];

   // flags are reset; the tag array is not and is qualified by valid
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_r <= '0;
         dirty_r <= '0;
      end else if (fill_en) begin
         valid_r[idx] <= 1'b1;
         dirty_r[idx] <= 1'b0;
      end else if (mark_dirty) begin
         dirty_r[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_r[idx] <= fill_tag;
   end

   assign tag_q   = tag_r[idx];
   assign valid_q = valid_r[idx];
   assign dirty_q = dirty_r[idx];
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
   parameter int NUM_BLK   = 1024,
   parameter int IDX_W     = 10,
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int WSEL_W    = 2,
   localparam int BLK_W    = WORD_W * BLK_WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   output logic [BLK_W-1:0]  blk_q,
   input  logic              fill_en,
   input  logic [BLK_W-1:0]  fill_blk,
   input  logic              word_we,
   input  logic [WSEL_W-1:0] word_sel,
   input  logic [WORD_W-1:0] word_data
);
   // one storage lane per word so a single-word write touches one lane
   for (genvar w = 0; w < BLK_WORDS; w++) begin : g_lane
      logic [WORD_W-1:0] lane_r [NUM_BLK];
      always_ff @(posedge clk) begin
         if (fill_en)
            lane_r[idx] <= fill_blk[w*WORD_W +: WORD_W];
         else if (word_we && (word_sel == WSEL_W'(w)))
            lane_r[idx] <= word_data;
      end
      assign blk_q[w*WORD_W +: WORD_W] = lane_r[idx];
   end
endmodule

// File: rtl/wbc_ctrl_fsm.sv
module wbc_ctrl_fsm
   import wbc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       hit,
   input  logic       victim_dirty,
   input  logic       mem_ready,
   output wbc_state_e state
);
   wbc_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (req_valid) state_nx = ST_CMP;
         ST_CMP: begin
            if (hit)               state_nx = ST_IDLE;
            else if (victim_dirty) state_nx = ST_WB;
            else                   state_nx = ST_FILL;
         end
         ST_WB:   if (mem_ready) state_nx = ST_FILL;
         ST_FILL: if (mem_ready) state_nx = ST_CMP;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end
endmodule

// File: rtl/blk_wb_cache.sv
module blk_wb_cache
   import wbc_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 4,
   parameter int NUM_BLK   = 1024,
   localparam int BLK_W    = WORD_W * BLK_WORDS,
   localparam int BYTE_W   = $clog2(WORD_W / 8),
   localparam int WSEL_W   = $clog2(BLK_WORDS),
   localparam int OFF_W    = BYTE_W + WSEL_W,
   localparam int IDX_W    = $clog2(NUM_BLK),
   localparam int TAG_W    = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_valid,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BLK_W-1:0]  mem_wdata,
   input  logic [BLK_W-1:0]  mem_rdata,
   input  logic              mem_ready
);
   initial begin
      assert ((1 << IDX_W) == NUM_BLK) else $error("NUM_BLK must be a power of two");
      assert ((1 << WSEL_W) == BLK_WORDS && BLK_WORDS >= 2) else $error("BLK_WORDS must be a power of two, at least 2");
      assert (WORD_W >= 8 && (8 << BYTE_W) == WORD_W) else $error("WORD_W must be a power-of-two number of bytes");
      assert (TAG_W >= 1) else $error("address too narrow for the cache geometry");
   end

   wbc_state_e state;

   // request captured when accepted, held for the whole access
   logic              req_wr;
   logic [ADDR_W-1:0] req_addr;
   logic [WORD_W-1:0] req_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_wr    <= 1'b0;
         req_addr  <= '0;
         req_wdata <= '0;
      end else if (state == ST_IDLE && cpu_valid) begin
         req_wr    <= cpu_wr;
         req_addr  <= cpu_addr;
         req_wdata <= cpu_wdata;
      end
   end

   logic [IDX_W-1:0]  req_idx;
   logic [TAG_W-1:0]  req_tag;
   logic [WSEL_W-1:0] req_wsel;
   assign req_wsel = req_addr[BYTE_W +: WSEL_W];
   assign req_idx  = req_addr[OFF_W +: IDX_W];
   assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];

   logic [TAG_W-1:0] ent_tag;
   logic             ent_valid;
   logic             ent_dirty;
   logic [BLK_W-1:0] ent_blk;
   logic             hit;
   logic             fill_en;
   logic             word_we;

   assign hit     = (state == ST_CMP) && ent_valid && (ent_tag == req_tag);
   assign fill_en = (state == ST_FILL) && mem_ready;
   assign word_we = hit && req_wr;

   wbc_ctrl_fsm i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (cpu_valid),
      .hit          (hit),
      .victim_dirty (ent_valid && ent_dirty),
      .mem_ready    (mem_ready),
      .state        (state)
   );

   wbc_tag_store #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx        (req_idx),
      .tag_q      (ent_tag),
      .valid_q    (ent_valid),
      .dirty_q    (ent_dirty),
      .fill_en    (fill_en),
      .fill_tag   (req_tag),
      .mark_dirty (word_we)
   );

   wbc_data_store #(
      .NUM_BLK(NUM_BLK), .IDX_W(IDX_W), .WORD_W(WORD_W),
      .BLK_WORDS(BLK_WORDS), .WSEL_W(WSEL_W)
   ) i_data (
      .clk       (clk),
      .idx       (req_idx),
      .blk_q     (ent_blk),
      .fill_en   (fill_en),
      .fill_blk  (mem_rdata),
      .word_we   (word_we),
      .word_sel  (req_wsel),
      .word_data (req_wdata)
   );

   assign cpu_ready = hit;
   assign cpu_rdata = ent_blk[req_wsel*WORD_W +: WORD_W];

   assign mem_valid = (state == ST_WB) || (state == ST_FILL);
   assign mem_wr    = (state == ST_WB);
   assign mem_addr  = (state == ST_WB) ? {ent_tag, req_idx, {OFF_W{1'b0}}}
                                       : {req_tag, req_idx, {OFF_W{1'b0}}};
   assign mem_wdata = ent_blk;
endmodule

// File: rtl/blk_wb_cache_chk.sv
module blk_wb_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int BLK_W  = 128,
   parameter int OFF_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_ready,
   input logic              mem_valid,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [BLK_W-1:0]  mem_wdata,
   input logic              mem_ready
);
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wr));

   a_r8_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_wr && !mem_ready |=> $stable(mem_wdata));

   a_r6_fetch_follows_wb: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_wr && mem_ready |=> mem_valid && !mem_wr);

   a_r7_compare_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_wr && mem_ready |=> !mem_valid);

   a_r5_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_addr[OFF_W-1:0] == '0);

   a_r9_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   a_r9_no_ready_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_valid);
endmodule

bind blk_wb_cache blk_wb_cache_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .OFF_W(OFF_W)) i_chk (.*);

// File: tb/test_blk_wb_cache.sv
module test_blk_wb_cache;
   localparam int NB = 4;          // index = addr[5:4], tag = addr[31:6]
   localparam int MEM_BLKS = 64;   // model memory covers addr[9:4]

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_valid = 1'b0;
   logic         cpu_wr = 1'b0;
   logic [31:0]  cpu_addr = '0;
   logic [31:0]  cpu_wdata = '0;
   logic [31:0]  cpu_rdata;
   logic         cpu_ready;
   logic         mem_valid;
   logic         mem_wr;
   logic [31:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic [127:0] mem_rdata;
   logic         mem_ready;

   always #5 clk = ~clk;

   blk_wb_cache #(.NUM_BLK(NB)) i_blk_wb_cache (.*);

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- memory responder ----------------
   logic [127:0] mem_blk [MEM_BLKS];
   logic [31:0]  ref_w [MEM_BLKS*4];
   int           mem_lat = 0;
   int           n_rd = 0;
   int           n_wr = 0;
   logic [31:0]  last_wb = '0;
   logic         busy = 1'b0;
   int           cnt = 0;
   logic [31:0]  hold_addr = '0;
   logic         hold_wr = 1'b0;

   assign mem_rdata = mem_blk[mem_addr[9:4]];

   initial mem_ready = 1'b0;
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ready <= 1'b0;
         busy      <= 1'b0;
      end else if (mem_ready) begin
         mem_ready <= 1'b0;
         busy      <= 1'b0;
      end else if (!busy && mem_valid) begin
         busy      <= 1'b1;
         cnt       <= mem_lat;
         hold_addr <= mem_addr;
         hold_wr   <= mem_wr;
      end else if (busy) begin
         // R8: request must not move while it waits
         if (mem_addr !== hold_addr || mem_wr !== hold_wr || !mem_valid) begin
            errors++;
            $display("FAIL R8 actual=%0h expected=%0h", mem_addr, hold_addr);
         end
         if (cnt == 0) begin
            mem_ready <= 1'b1;
            if (hold_wr) begin
               mem_blk[mem_addr[9:4]] <= mem_wdata;
               n_wr    <= n_wr + 1;
               last_wb <= mem_addr;
            end else begin
               n_rd <= n_rd + 1;
            end
         end else begin
            cnt <= cnt - 1;
         end
      end
   end

   // ---------------- processor access task ----------------
   task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int nr, output int nw, output int waits);
      int r0, w0;
      @(negedge clk);
      r0 = n_rd; w0 = n_wr;
      cpu_valid = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
      waits = 0;
      do begin
         @(negedge clk);
         waits++;
      end while (!cpu_ready && waits < 300);
      rd = cpu_rdata;
      @(negedge clk);
      nr = n_rd - r0; nw = n_wr - w0;
      cpu_valid = 1'b0;
      check(waits < 300, "R9 completion", waits, 0);
      check(!cpu_ready, "R9 single ready", cpu_ready, 0);
      if (wr) ref_w[a[9:2]] = d;
   endtask

   // ---------------- vector table ----------------
   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [31:0] exp;   // expected read word
      logic [1:0]  kind;  // 0 hit, 1 clean miss, 2 dirty miss
      logic [31:0] wb;    // expected write-back address for kind 2
      logic [3:0]  req;   // requirement number reported
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h00, 32'h0,        32'hC000_0000, 2'd1, 32'h0,  4'd2},  // R2 cold miss
      '{1'b0, 32'h04, 32'h0,        32'hC000_0004, 2'd0, 32'h0,  4'd3},  // R3 read hit
      '{1'b1, 32'h08, 32'h1111_1111, 32'h0,        2'd0, 32'h0,  4'd4},  // R4 write hit
      '{1'b0, 32'h08, 32'h0,        32'h1111_1111, 2'd0, 32'h0,  4'd4},  // R4 word updated
      '{1'b0, 32'h40, 32'h0,        32'hC000_0040, 2'd2, 32'h00, 4'd6},  // R6 dirty victim
      '{1'b0, 32'h00, 32'h0,        32'hC000_0000, 2'd1, 32'h0,  4'd10}, // R10 clean victim
      '{1'b0, 32'h08, 32'h0,        32'h1111_1111, 2'd0, 32'h0,  4'd6},  // R6 data survived
      '{1'b1, 32'h5C, 32'h2222_2222, 32'h0,        2'd1, 32'h0,  4'd7},  // R7 write miss
      '{1'b0, 32'h5C, 32'h0,        32'h2222_2222, 2'd0, 32'h0,  4'd7},  // R7 merged word
      '{1'b0, 32'h50, 32'h0,        32'hC000_0050, 2'd0, 32'h0,  4'd1},  // R1 other lane
      '{1'b0, 32'h1C, 32'h0,        32'hC000_001C, 2'd2, 32'h50, 4'd6},  // R6 victim address
      '{1'b0, 32'h5C, 32'h0,        32'h2222_2222, 2'd1, 32'h0,  4'd5},  // R5 refetch
      '{1'b1, 32'h30, 32'h3333_3333, 32'h0,        2'd1, 32'h0,  4'd7},  // R7 write miss
      '{1'b1, 32'h34, 32'h4444_4444, 32'h0,        2'd0, 32'h0,  4'd4},  // R4 second word
      '{1'b0, 32'h70, 32'h0,        32'hC000_0070, 2'd2, 32'h30, 4'd6},  // R6 eviction
      '{1'b0, 32'h34, 32'h0,        32'h4444_4444, 2'd1, 32'h0,  4'd1},  // R1 word select
      '{1'b0, 32'h30, 32'h0,        32'h3333_3333, 2'd0, 32'h0,  4'd3}   // R3 read hit
   };

   initial begin
      logic [31:0] rd;
      int nr, nw, waits;
      string tag;
      for (int b = 0; b < MEM_BLKS; b++) begin
         for (int k = 0; k < 4; k++) begin
            mem_blk[b][32*k +: 32] = 32'hC000_0000 | 32'(b*16 + k*4);
            ref_w[b*4 + k]         = 32'hC000_0000 | 32'(b*16 + k*4);
         end
      end
      repeat (3) @(negedge clk);
      check(!cpu_ready, "R2 reset ready", cpu_ready, 0);
      check(!mem_valid, "R2 reset mem_valid", mem_valid, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         tag = $sformatf("R%0d vec %0d", VEC[i].req, i);
         mem_lat = i % 3;
         access(VEC[i].wr, VEC[i].addr, VEC[i].wdata, rd, nr, nw, waits);
         if (!VEC[i].wr) check(rd == VEC[i].exp, {tag, " data"}, rd, VEC[i].exp);
         check(nr == (VEC[i].kind != 0 ? 1 : 0), {tag, " reads"}, nr, VEC[i].kind != 0);
         check(nw == (VEC[i].kind == 2 ? 1 : 0), {tag, " writes"}, nw, VEC[i].kind == 2);
         if (VEC[i].kind == 0) check(waits == 1, {tag, " hit latency R3"}, waits, 1);
         if (VEC[i].kind == 2) check(last_wb == VEC[i].wb, {tag, " victim addr"}, last_wb, VEC[i].wb);
      end

      // conflict-heavy mixed traffic against the reference words (R4, R6)
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         logic        w;
         logic [31:0] d;
         a = {22'h0, 6'($urandom_range(0, MEM_BLKS-1)), 2'($urandom_range(0, 3)), 2'b00};
         w = ($urandom_range(0, 2) == 0);
         d = $urandom;
         mem_lat = $urandom_range(0, 4);
         access(w, a, d, rd, nr, nw, waits);
         if (!w) check(rd == ref_w[a[9:2]], "R4 random read", rd, ref_w[a[9:2]]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule